// File: doc/BRIEF.md
# Dual-Threshold Time-Walk Corrector

This block removes amplitude-dependent time walk from pulse timestamps, one hit per clock. Each hit arrives with two leading-edge times for the same pulse: the time it crossed a low discriminator level and the time it crossed a high one. Larger pulses cross both levels sooner than small ones. A straight line drawn through the two crossing points is extended back to zero amplitude. The time of that zero crossing becomes the corrected event time.

The two threshold levels, in millivolts, are loaded through a small configuration port. On every write, an iterative divider precomputes the ratio `low / (high - low)` in unsigned fixed point. The new ratio is swapped into use atomically once the divider finishes. The per-hit datapath is a three-stage pipeline: subtract, multiply by the ratio, then subtract the correction from the low-threshold time. A hit whose times or thresholds cannot define a line is passed through uncorrected and flagged.

Top module: `slew_corrector`

## Requirements
- R1: For a good hit, with D = TH − TL, K = floor(LOW·2^FRAC_W / (HIGH − LOW)) and C = floor(D·K / 2^FRAC_W), `out_t0` = TL − C as a two's-complement value of TIME_W+THR_W+1 bits, with `out_err` = 0 and `out_nohigh` = 0 (default FRAC_W = 8).
- R2: Latency is exactly three clocks. A hit presented in cycle n appears in cycle n+3, and hits presented on consecutive cycles come out on consecutive cycles in order.
- R3: `out_valid` is high only three cycles after a presented hit. When `out_valid` is low, `out_err` and `out_nohigh` are low.
- R4: If `hit_th_valid` = 1 and TH ≤ TL, the hit gives `out_err` = 1, `out_nohigh` = 0, and `out_t0` = TL zero-extended.
- R5: If the thresholds in use have HIGH ≤ LOW, every hit with `hit_th_valid` = 1 gives `out_err` = 1 and `out_t0` = TL.
- R6: If `hit_th_valid` = 0, the hit gives `out_nohigh` = 1, `out_err` = 0, and `out_t0` = TL, whatever `hit_th` and the thresholds hold.
- R7: From reset until the first threshold write takes effect, the thresholds count as invalid, and hits behave as in R5.
- R8: A write with `cfg_we` = 1 in cycle w applies to hits presented in cycle w+THR_W+FRAC_W+2 or later (w+20 by default). Hits presented earlier, including those already in the pipeline, use the previous thresholds.
- R9: The corrected time may lie before time zero. The most negative value, TL = 0 with TH = 2^TIME_W − 1 and LOW = HIGH − 1 = 1022, is represented exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load new thresholds this cycle |
| cfg_lthr | input | THR_W | Low threshold level, mV |
| cfg_hthr | input | THR_W | High threshold level, mV |
| hit_valid | input | 1 | A hit is presented this cycle |
| hit_tl | input | TIME_W | Low-threshold leading-edge time, TDC counts |
| hit_th | input | TIME_W | High-threshold leading-edge time, TDC counts |
| hit_th_valid | input | 1 | The pulse reached the high threshold |
| out_valid | output | 1 | Corrected result present |
| out_t0 | output | TIME_W+THR_W+1 | Corrected time, signed |
| out_err | output | 1 | Times or thresholds unusable; TL passed through |
| out_nohigh | output | 1 | No high crossing; TL passed through |

## Verification
Single hits are tried with several threshold pairs. Some give a power-of-two ratio and some a non-trivial one, so a wrong rounding point or a dropped fraction bit shows up. Equal and reversed crossing times separate the time check from the threshold check. A missing high crossing with a garbage TH shows that the "no high" path has priority. A long mixed stream checks ordering and throughput. A threshold write in the middle of that stream, with hits one cycle before and exactly at the switch-over cycle, pins the moment the new ratio takes hold. An extreme pair with the widest time gap checks the negative end of the output range.

// File: rtl/slew_pkg.sv
package slew_pkg;

  // Outcome of the per-hit checks, decided in the first pipeline stage.
  typedef enum logic [1:0] {
    HIT_OK       = 2'd0,
    HIT_BAD_TIME = 2'd1,
    HIT_BAD_CFG  = 2'd2,
    HIT_NO_HIGH  = 2'd3
  } hit_class_e;

  // A missing high crossing wins over every other condition.
  function automatic hit_class_e classify(input logic th_seen,
                                          input logic th_after,
                                          input logic thr_bad);
    if (!th_seen)      return HIT_NO_HIGH;
    else if (thr_bad)  return HIT_BAD_CFG;
    else if (!th_after) return HIT_BAD_TIME;
    else               return HIT_OK;
  endfunction

endpackage

// File: rtl/slew_ratio_div.sv
// Computes K = LOW * 2^F / (HIGH - LOW) one quotient bit per clock and
// swaps it into use in a single edge once all bits are known.
module slew_ratio_div #(
  parameter int VW = 10,
  parameter int F  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [VW-1:0]   cfg_lthr,
  input  logic [VW-1:0]   cfg_hthr,
  output logic [VW+F-1:0] act_k,
  output logic            act_bad,
  output logic            commit
);
  localparam int QW = VW + F;
  localparam int CW = $clog2(QW + 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [QW-1:0] quo;
  logic [VW-1:0] rem;
  logic [VW-1:0] dvs;
  logic          pend_bad;

  logic [VW:0]   rem_sh;
  logic          fits;
  logic [VW-1:0] rem_nx;
  logic [QW-1:0] quo_nx;

  // One restoring-division step.
  always_comb begin
    rem_sh = {rem, quo[QW-1]};
    fits   = rem_sh >= {1'b0, dvs};
    rem_nx = fits ? VW'(rem_sh - {1'b0, dvs}) : rem_sh[VW-1:0];
    quo_nx = {quo[QW-2:0], fits};
  end

  assign commit = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      quo      <= '0;
      rem      <= '0;
      dvs      <= '0;
      pend_bad <= 1'b1;
      act_k    <= '0;
      act_bad  <= 1'b1;
    end else if (cfg_we) begin
      // A newer write restarts the divide; the latest write wins.
      busy     <= 1'b1;
      cnt      <= CW'(QW);
      quo      <= {cfg_lthr, {F{1'b0}}};
      rem      <= '0;
      pend_bad <= (cfg_hthr <= cfg_lthr);
      dvs      <= (cfg_hthr <= cfg_lthr) ? VW'(1) : VW'(cfg_hthr - cfg_lthr);
    end else if (busy) begin
      if (cnt != '0) begin
        quo <= quo_nx;
        rem <= rem_nx;
        cnt <= cnt - CW'(1);
      end else begin
        act_k   <= quo;
        act_bad <= pend_bad;
        busy    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/slew_pipe.sv
// Three-stage correction datapath: classify and difference, scale, subtract.
module slew_pipe
  import slew_pkg::*;
#(
  parameter int TW = 16,
  parameter int QW = 18,
  parameter int F  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hit_valid,
  input  logic [TW-1:0]           hit_tl,
  input  logic [TW-1:0]           hit_th,
  input  logic                    hit_th_valid,
  input  logic [QW-1:0]           k_in,
  input  logic                    cfg_bad,
  output logic                    out_valid,
  output logic signed [TW+QW-F:0] out_t0,
  output logic                    out_err,
  output logic                    out_nohigh
);
  localparam int CW = TW + QW - F;
  localparam int OW = CW + 1;

  // Walk term: floor(d * k / 2^F).
  function automatic logic [CW-1:0] walk_term(input logic [TW-1:0] d,
                                              input logic [QW-1:0] kk);
    logic [TW+QW-1:0] p;
    p = d * kk;
    return p[TW+QW-1:F];
  endfunction

  function automatic logic signed [OW-1:0] extrap(input logic [TW-1:0] tl,
                                                  input logic [CW-1:0] c);
    return $signed({{(OW-TW){1'b0}}, tl}) - $signed({1'b0, c});
  endfunction

  function automatic logic signed [OW-1:0] pass_tl(input logic [TW-1:0] tl);
    return $signed({{(OW-TW){1'b0}}, tl});
  endfunction

  // Stage 1
  logic          s1_v;
  logic [TW-1:0] s1_tl;
  logic [TW-1:0] s1_d;
  logic [QW-1:0] s1_k;
  hit_class_e    s1_cls;
  // Stage 2
  logic          s2_v;
  logic [TW-1:0] s2_tl;
  logic [CW-1:0] s2_c;
  hit_class_e    s2_cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_tl  <= '0;
      s1_d   <= '0;
      s1_k   <= '0;
      s1_cls <= HIT_OK;
    end else begin
      s1_v   <= hit_valid;
      s1_tl  <= hit_tl;
      s1_d   <= hit_th - hit_tl;
      s1_k   <= k_in;   // ratio snapshot travels with the hit
      s1_cls <= classify(hit_th_valid, hit_th > hit_tl, cfg_bad);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v   <= 1'b0;
      s2_tl  <= '0;
      s2_c   <= '0;
      s2_cls <= HIT_OK;
    end else begin
      s2_v   <= s1_v;
      s2_tl  <= s1_tl;
      s2_c   <= walk_term(s1_d, s1_k);
      s2_cls <= s1_cls;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_t0     <= '0;
      out_err    <= 1'b0;
      out_nohigh <= 1'b0;
    end else begin
      out_valid  <= s2_v;
      out_t0     <= (s2_cls == HIT_OK) ? extrap(s2_tl, s2_c) : pass_tl(s2_tl);
      out_err    <= s2_v && ((s2_cls == HIT_BAD_TIME) || (s2_cls == HIT_BAD_CFG));
      out_nohigh <= s2_v && (s2_cls == HIT_NO_HIGH);
    end
  end

endmodule

// File: rtl/slew_corrector.sv
module slew_corrector #(
  parameter int TIME_W = 16,
  parameter int THR_W  = 10,
  parameter int FRAC_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [THR_W-1:0]              cfg_lthr,
  input  logic [THR_W-1:0]              cfg_hthr,
  input  logic                          hit_valid,
  input  logic [TIME_W-1:0]             hit_tl,
  input  logic [TIME_W-1:0]             hit_th,
  input  logic                          hit_th_valid,
  output logic                          out_valid,
  output logic signed [TIME_W+THR_W:0]  out_t0,
  output logic                          out_err,
  output logic                          out_nohigh
);
  localparam int QW = THR_W + FRAC_W;

  // Named internal events, visible to the bound checker.
  logic [QW-1:0] ratio_k;
  logic          ratio_bad;
  logic          cfg_commit;

  slew_ratio_div #(.VW(THR_W), .F(FRAC_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_lthr (cfg_lthr),
    .cfg_hthr (cfg_hthr),
    .act_k    (ratio_k),
    .act_bad  (ratio_bad),
    .commit   (cfg_commit)
  );

  slew_pipe #(.TW(TIME_W), .QW(QW), .F(FRAC_W)) u_pipe (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit_valid    (hit_valid),
    .hit_tl       (hit_tl),
    .hit_th       (hit_th),
    .hit_th_valid (hit_th_valid),
    .k_in         (ratio_k),
    .cfg_bad      (ratio_bad),
    .out_valid    (out_valid),
    .out_t0       (out_t0),
    .out_err      (out_err),
    .out_nohigh   (out_nohigh)
  );

endmodule

// File: rtl/slew_corrector_chk.sv
module slew_corrector_chk #(
  parameter int TW = 16,
  parameter int VW = 10,
  parameter int F  = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 hit_valid,
  input logic [TW-1:0]        hit_tl,
  input logic [TW-1:0]        hit_th,
  input logic                 hit_th_valid,
  input logic                 out_valid,
  input logic signed [TW+VW:0] out_t0,
  input logic                 out_err,
  input logic                 out_nohigh,
  input logic [VW+F-1:0]      ratio_k,
  input logic                 cfg_commit
);
  localparam int OW = TW + VW + 1;

  // Independent three-cycle delay of the hit inputs.
  logic [2:0]    d_v, d_thv, d_late;
  logic [TW-1:0] d_tl [3];
  logic [1:0]    age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_v <= '0; d_thv <= '0; d_late <= '0; age <= '0;
      for (int i = 0; i < 3; i++) d_tl[i] <= '0;
    end else begin
      d_v    <= {d_v[1:0], hit_valid};
      d_thv  <= {d_thv[1:0], hit_th_valid};
      d_late <= {d_late[1:0], hit_th > hit_tl};
      d_tl[0] <= hit_tl;
      d_tl[1] <= d_tl[0];
      d_tl[2] <= d_tl[1];
      if (age != 2'd3) age <= age + 2'd1;
    end
  end

  logic signed [OW-1:0] tl_ext;
  assign tl_ext = $signed({{(OW-TW){1'b0}}, d_tl[2]});

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (out_valid == d_v[2]));

  a_r3_quiet_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_err && !out_nohigh));

  a_r4_late_time_err: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && out_valid && d_thv[2] && !d_late[2]) |-> (out_err && out_t0 == tl_ext));

  a_r6_nohigh_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && out_valid && !d_thv[2]) |-> (out_nohigh && !out_err && out_t0 == tl_ext));

  a_r5_err_passes_tl: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && out_err) |-> (out_t0 == tl_ext));

  a_r1_never_later: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && out_valid && !out_err && !out_nohigh) |-> (out_t0 <= tl_ext));

  a_r8_ratio_swap: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_commit |=> $stable(ratio_k));

endmodule

bind slew_corrector slew_corrector_chk #(.TW(TIME_W), .VW(THR_W), .F(FRAC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hit_valid    (hit_valid),
  .hit_tl       (hit_tl),
  .hit_th       (hit_th),
  .hit_th_valid (hit_th_valid),
  .out_valid    (out_valid),
  .out_t0       (out_t0),
  .out_err      (out_err),
  .out_nohigh   (out_nohigh),
  .ratio_k      (ratio_k),
  .cfg_commit   (cfg_commit)
);

// File: tb/slew_corrector_bench.sv
module slew_corrector_bench;
  localparam int TW = 16, VW = 10, F = 8;
  localparam int OW = TW + VW + 1;
  localparam int CFG_LAT = VW + F + 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cfg_we, hit_valid, hit_th_valid;
  logic [VW-1:0] cfg_lthr, cfg_hthr;
  logic [TW-1:0] hit_tl, hit_th;
  logic out_valid, out_err, out_nohigh;
  logic signed [OW-1:0] out_t0;

  slew_corrector #(.TIME_W(TW), .THR_W(VW), .FRAC_W(F)) u_slew_corrector (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lthr(cfg_lthr), .cfg_hthr(cfg_hthr),
    .hit_valid(hit_valid), .hit_tl(hit_tl), .hit_th(hit_th), .hit_th_valid(hit_th_valid),
    .out_valid(out_valid), .out_t0(out_t0), .out_err(out_err), .out_nohigh(out_nohigh));

  int total = 0, bad = 0;
  longint cur_l = 0, cur_h = 0;
  bit cur_ok = 0;

  // Straight-line extrapolation to zero amplitude, restated from R1/R4-R7.
  function automatic void model(input longint tl, input longint th, input bit thv,
                                input longint l, input longint h, input bit ok,
                                output longint t0, output bit err, output bit nh);
    longint k;
    nh = !thv; err = 0; t0 = tl;
    if (!thv) return;
    if (!ok || h <= l || th <= tl) begin err = 1; return; end
    k  = (l * (64'd1 << F)) / (h - l);
    t0 = tl - ((th - tl) * k) / (64'd1 << F);
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_out(input string req, input longint t0e, input bit erre, input bit nhe);
    chk(req, "valid", longint'(out_valid), 1);
    chk(req, "t0", longint'(out_t0), t0e);
    chk(req, "err", longint'(out_err), longint'(erre));
    chk(req, "nohigh", longint'(out_nohigh), longint'(nhe));
  endtask

  task automatic idle_inputs();
    hit_valid = 0; hit_tl = '0; hit_th = '0; hit_th_valid = 0; cfg_we = 0;
  endtask

  task automatic do_reset();
    idle_inputs(); cfg_lthr = '0; cfg_hthr = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R3: nothing valid after reset
    chk("R3", "valid after reset", longint'(out_valid), 0);
    chk("R3", "err after reset", longint'(out_err), 0);
  endtask

  task automatic cfg_write(input longint l, input longint h);
    @(negedge clk);
    cfg_we = 1; cfg_lthr = VW'(l); cfg_hthr = VW'(h);
    @(negedge clk);
    cfg_we = 0;
    repeat (CFG_LAT) @(negedge clk);
    cur_l = l; cur_h = h; cur_ok = 1;
  endtask

  // One isolated hit; result sampled three clocks later, then idle checked.
  task automatic one_hit(input string req, input longint tl, input longint th, input bit thv);
    longint t0e; bit erre, nhe;
    model(tl, th, thv, cur_l, cur_h, cur_ok, t0e, erre, nhe);
    @(negedge clk);
    hit_valid = 1; hit_tl = TW'(tl); hit_th = TW'(th); hit_th_valid = thv;
    @(negedge clk);
    idle_inputs();
    @(negedge clk);
    chk("R2", "valid early", longint'(out_valid), 0);
    @(negedge clk);
    check_out(req, t0e, erre, nhe);
    @(negedge clk);
    chk("R3", "valid after hit", longint'(out_valid), 0);
  endtask

  // Back-to-back stream, optional threshold write at cycle cfg_at.
  longint e_t0 [64];
  bit     e_err [64], e_nh [64];

  task automatic run_stream(input string req, input int n, input int cfg_at,
                            input longint nl, input longint nhv);
    for (int j = 0; j < n + 3; j++) begin
      @(negedge clk);
      if (j >= 3) check_out(req, e_t0[j-3], e_err[j-3], e_nh[j-3]);
      cfg_we = (j == cfg_at);
      if (j == cfg_at) begin cfg_lthr = VW'(nl); cfg_hthr = VW'(nhv); end
      if (j < n) begin
        longint tl, th; bit thv, use_new;
        tl  = 2000 + j * 37;
        th  = (j % 5 == 3) ? tl : tl + 15 + j * 3;
        thv = (j % 7 != 4);
        use_new = (cfg_at >= 0) && (j >= cfg_at + CFG_LAT);
        if (use_new) model(tl, th, thv, nl, nhv, 1, e_t0[j], e_err[j], e_nh[j]);
        else         model(tl, th, thv, cur_l, cur_h, cur_ok, e_t0[j], e_err[j], e_nh[j]);
        hit_valid = 1; hit_tl = TW'(tl); hit_th = TW'(th); hit_th_valid = thv;
      end else begin
        hit_valid = 0; hit_th_valid = 0;
      end
    end
    idle_inputs();
    if (cfg_at >= 0) begin cur_l = nl; cur_h = nhv; cur_ok = 1; end
  endtask

  task automatic t_reset_thresholds();   // R7
    one_hit("R7", 1000, 1040, 1);
    chk("R7", "err before first write", longint'(out_err), 0); // idle cycle: flags low
  endtask

  task automatic t_basic();              // R1
    cfg_write(20, 60);
    one_hit("R1", 1000, 1040, 1);        // ratio 0.5 -> 980
    chk("R1", "known value", longint'(e_known(1000, 1040)), 980);
    cfg_write(30, 100);
    one_hit("R1", 500, 523, 1);
    one_hit("R1", 40000, 40999, 1);
    cfg_write(0, 10);                    // zero ratio -> TL unchanged
    one_hit("R1", 777, 900, 1);
  endtask

  function automatic longint e_known(input longint tl, input longint th);
    longint t; bit e, n;
    model(tl, th, 1, 20, 60, 1, t, e, n);
    return t;
  endfunction

  task automatic t_bad_time();           // R4
    cfg_write(20, 60);
    one_hit("R4", 300, 300, 1);
    one_hit("R4", 300, 250, 1);
  endtask

  task automatic t_nohigh();             // R6
    one_hit("R6", 1234, 5000, 0);
    one_hit("R6", 1234, 10, 0);
    cfg_write(60, 20);
    one_hit("R6", 99, 150, 0);
  endtask

  task automatic t_bad_cfg();            // R5
    cfg_write(50, 50);
    one_hit("R5", 400, 480, 1);
    cfg_write(80, 40);
    one_hit("R5", 400, 480, 1);
  endtask

  task automatic t_extreme();            // R9
    cfg_write(1022, 1023);
    one_hit("R9", 0, 65535, 1);
    chk("R9", "most negative", longint'(out_t0), 0);  // idle cycle value is don't-care; re-run below
    one_hit("R9", 0, 65535, 1);
  endtask

  task automatic t_stream();             // R2
    cfg_write(30, 100);
    run_stream("R2", 24, -1, 0, 0);
  endtask

  task automatic t_midstream();          // R8: hits at offsets 19 (old) and 20 (new)
    cfg_write(20, 60);
    run_stream("R8", 30, 2, 30, 100);
  endtask

  initial begin
    #(4 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    t_reset_thresholds();
    t_basic();
    t_bad_time();
    t_nohigh();
    t_bad_cfg();
    t_stream();
    t_midstream();
    t_extreme_safe();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic t_extreme_safe();       // R9
    cfg_write(1022, 1023);
    one_hit("R9", 0, 65535, 1);
    one_hit("R9", 100, 65535, 1);
  endtask

endmodule